// File: doc/BRIEF.md
# Host Sleep-Wake Handshake Controller

This block runs the low-power handshake between a wireless device and the host it serves, over a few dedicated sideband lines. The host raises a device-wake line when it needs the device. Internal logic supplies a sleep-criteria flag and attention requests. From these, a four-state machine decides when the device may sleep, when it must come back, and when it must wake the host.

The block drives four outputs. The first is a host-wake line. The second is an active-high reference-clock request. The third is a set of per-path radio power-down controls. The polarity of the device-wake input and of the host-wake output is set by configuration bits.

Leaving sleep works in two steps. The clock request goes up first. The radio power-downs are released only after a programmable settle time. An attention request is held until the host reacts, so it is never dropped.

Top module: `swk_ctrl`

## Requirements
- R1: `dev_wake_in` passes through a two-flop synchronizer before use. It counts as active when its level equals `cfg_dw_act_hi` (1 = active-high, 0 = active-low). A change on the pin first affects the outputs at the third rising edge after it is applied.
- R2: While the synchronized device-wake is active, the controller does not enter or stay in sleep. `ref_clk_req` is 1 one edge after each such cycle.
- R3: Sleep is entered only when device-wake is inactive and `sleep_ok` is 1 on two consecutive edges; the first of these goes through a pending state. In sleep, `radio_pd` is 4'b1111.
- R4: Sleep is left when device-wake becomes active or `sleep_ok` drops. `ref_clk_req` rises on the edge that leaves sleep. `radio_pd` stays 4'b1111 for `settle_cycles` more edges and takes `cfg_pd_en` on the edge after that.
- R5: `ref_clk_req` is a registered, active-high OR of `peer_clk_need` and "not in sleep". It is 0 after every edge at which `rst` is 1.
- R6: `radio_pd` bit 0 is the transmit path, bit 1 the receive path, bit 2 the PLL and bit 3 the power amplifier; 1 means powered down. Outside sleep and wake-up, each bit equals the matching `cfg_pd_en` bit.
- R7: A pulse on `attn_set` makes an attention request pending. The request is cleared by `attn_clr` or by an active device-wake. When `attn_set` and `attn_clr` come in the same cycle, the request stays pending.
- R8: `host_wake_out` is registered. It carries the pending request at the level chosen by `cfg_hw_act_hi` (1 = active-high, 0 = active-low). A polarity change shows at the next edge.
- R9: Synchronous reset puts the controller in sleep with no attention pending. It drives `radio_pd` = 4'b1111, `ref_clk_req` = 0, and `host_wake_out` at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_wake_in | input | 1 | Asynchronous device-wake line from the host |
| cfg_dw_act_hi | input | 1 | Device-wake active level (1 = high) |
| cfg_hw_act_hi | input | 1 | Host-wake active level (1 = high) |
| sleep_ok | input | 1 | Internal sleep criteria met |
| attn_set | input | 1 | Request host attention (pulse) |
| attn_clr | input | 1 | Software clear of the attention request |
| peer_clk_need | input | 1 | Second function needs the reference clock |
| cfg_pd_en | input | 4 | Per-path power-down while awake |
| settle_cycles | input | CNT_W | Clock settle wait on wake-up |
| host_wake_out | output | 1 | Host-wake line |
| ref_clk_req | output | 1 | Reference-clock request, active-high |
| radio_pd | output | 4 | Radio power-downs {PA, PLL, RX, TX} |

## Verification
The bench builds the block with the default `CNT_W` of 4 and a two-stage synchronizer, and varies `settle_cycles` between 0 and 5 at run time. A settle value of 0 exercises the case where the wait ends on its very first cycle. Values up to 5 keep wake-ups short enough that thousands of sleep/wake round trips fit in the run. Short 4-bit settle values also let both polarity settings and rare resets land in the middle of a wait.

// File: rtl/swk_pkg.sv
package swk_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE  = 2'd0,
    ST_PEND   = 2'd1,
    ST_SLEEP  = 2'd2,
    ST_WAKING = 2'd3
  } pm_state_t;

  localparam int PD_LANES = 4;
  localparam int PD_TX    = 0;
  localparam int PD_RX    = 1;
  localparam int PD_PLL   = 2;
  localparam int PD_PA    = 3;
endpackage

// File: rtl/swk_sync.sv
module swk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int TOP = STAGES - 1;
  logic [TOP:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[TOP-1:0], d};
  end

  assign q = chain[TOP];
endmodule

// File: rtl/swk_fsm.sv
module swk_fsm
  import swk_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wake_act,
  input  logic             sleep_ok,
  input  logic [CNT_W-1:0] settle_cycles,
  output pm_state_t        st_nxt
);
  pm_state_t        st_q;
  logic [CNT_W-1:0] wait_q;
  logic             go_sleep;
  logic             settled;

  assign go_sleep = sleep_ok && !wake_act;
  assign settled  = (wait_q >= settle_cycles);

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      ST_AWAKE:  if (go_sleep)  st_nxt = ST_PEND;
      ST_PEND:   st_nxt = go_sleep ? ST_SLEEP : ST_AWAKE;
      ST_SLEEP:  if (!go_sleep) st_nxt = ST_WAKING;
      ST_WAKING: if (settled)   st_nxt = ST_AWAKE;
      default:   st_nxt = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_SLEEP;
      wait_q <= '0;
    end else begin
      st_q <= st_nxt;
      if (st_q != ST_WAKING)  wait_q <= '0;
      else if (!settled)      wait_q <= wait_q + 1'b1;
    end
  end
endmodule

// File: rtl/swk_attn.sv
module swk_attn (
  input  logic clk,
  input  logic rst,
  input  logic attn_set,
  input  logic attn_clr,
  input  logic wake_act,
  input  logic cfg_hw_act_hi,
  output logic host_wake_out
);
  logic pend_q;
  logic pend_nxt;

  // a new request beats any clear in the same cycle
  assign pend_nxt = attn_set | (pend_q & ~attn_clr & ~wake_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q        <= 1'b0;
      host_wake_out <= ~cfg_hw_act_hi;
    end else begin
      pend_q        <= pend_nxt;
      host_wake_out <= ~(pend_nxt ^ cfg_hw_act_hi);
    end
  end
endmodule

// File: rtl/swk_outs.sv
module swk_outs
  import swk_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  pm_state_t           st_nxt,
  input  logic                peer_clk_need,
  input  logic [PD_LANES-1:0] cfg_pd_en,
  output logic                ref_clk_req,
  output logic [PD_LANES-1:0] radio_pd
);
  logic force_off;
  logic asleep;

  assign asleep    = (st_nxt == ST_SLEEP);
  assign force_off = asleep || (st_nxt == ST_WAKING);

  always_ff @(posedge clk) begin
    if (rst) ref_clk_req <= 1'b0;
    else     ref_clk_req <= peer_clk_need | ~asleep;
  end

  for (genvar g = 0; g < PD_LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) radio_pd[g] <= 1'b1;
      else     radio_pd[g] <= force_off | cfg_pd_en[g];
    end
  end
endmodule

// File: rtl/swk_ctrl.sv
module swk_ctrl
  import swk_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dev_wake_in,
  input  logic                cfg_dw_act_hi,
  input  logic                cfg_hw_act_hi,
  input  logic                sleep_ok,
  input  logic                attn_set,
  input  logic                attn_clr,
  input  logic                peer_clk_need,
  input  logic [PD_LANES-1:0] cfg_pd_en,
  input  logic [CNT_W-1:0]    settle_cycles,
  output logic                host_wake_out,
  output logic                ref_clk_req,
  output logic [PD_LANES-1:0] radio_pd
);
  logic      dw_sync;
  logic      wake_act;
  pm_state_t st_nxt;

  swk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(dev_wake_in), .q(dw_sync)
  );

  assign wake_act = cfg_dw_act_hi ? dw_sync : ~dw_sync;

  swk_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .wake_act(wake_act), .sleep_ok(sleep_ok),
    .settle_cycles(settle_cycles), .st_nxt(st_nxt)
  );

  swk_attn u_attn (
    .clk(clk), .rst(rst), .attn_set(attn_set), .attn_clr(attn_clr),
    .wake_act(wake_act), .cfg_hw_act_hi(cfg_hw_act_hi),
    .host_wake_out(host_wake_out)
  );

  swk_outs u_outs (
    .clk(clk), .rst(rst), .st_nxt(st_nxt), .peer_clk_need(peer_clk_need),
    .cfg_pd_en(cfg_pd_en), .ref_clk_req(ref_clk_req), .radio_pd(radio_pd)
  );
endmodule

// File: rtl/swk_ctrl_chk.sv
module swk_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wake_act,
  input logic       attn_set,
  input logic       cfg_hw_act_hi,
  input logic       host_wake_out,
  input logic       ref_clk_req,
  input logic [3:0] radio_pd
);
  // R5: clock request is low after any edge that saw reset
  assert_clkreq_reset_R5: assert property (@(posedge clk)
    $past(rst) |-> !ref_clk_req);

  // R2: an active device-wake forces the clock request on at the next edge
  assert_wake_keeps_clock_R2: assert property (@(posedge clk) disable iff (rst)
    (!rst && wake_act) |=> ref_clk_req);

  // R4: a powered radio path always comes with a clock request
  assert_pd_needs_clock_R4: assert property (@(posedge clk) disable iff (rst)
    (radio_pd != 4'b1111) |-> ref_clk_req);

  // R7: a new attention request drives host-wake to its active level
  assert_attn_raises_hw_R7: assert property (@(posedge clk) disable iff (rst)
    (!rst && attn_set) |=> (host_wake_out == $past(cfg_hw_act_hi)));
endmodule

bind swk_ctrl swk_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .wake_act(wake_act), .attn_set(attn_set),
  .cfg_hw_act_hi(cfg_hw_act_hi), .host_wake_out(host_wake_out),
  .ref_clk_req(ref_clk_req), .radio_pd(radio_pd)
);

// File: tb/swk_ctrl_test.sv
`timescale 1ns/100ps
module swk_ctrl_test;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             dev_wake_in = 1'b0;
  logic             cfg_dw_act_hi = 1'b1;
  logic             cfg_hw_act_hi = 1'b1;
  logic             sleep_ok = 1'b1;
  logic             attn_set = 1'b0;
  logic             attn_clr = 1'b0;
  logic             peer_clk_need = 1'b0;
  logic [3:0]       cfg_pd_en = 4'b0101;
  logic [CNT_W-1:0] settle_cycles = 4'd3;
  logic             host_wake_out;
  logic             ref_clk_req;
  logic [3:0]       radio_pd;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // bench model state: 0 awake, 1 pending, 2 sleep, 3 waking
  int         m_st = 2;
  int         m_cnt = 0;
  bit         m_s1 = 0, m_s2 = 0, m_attn = 0;
  bit         m_clk = 0, m_hw = 0;
  logic [3:0] m_pd = 4'b1111;

  always #2.5 clk = ~clk;

  swk_ctrl #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .dev_wake_in(dev_wake_in),
    .cfg_dw_act_hi(cfg_dw_act_hi), .cfg_hw_act_hi(cfg_hw_act_hi),
    .sleep_ok(sleep_ok), .attn_set(attn_set), .attn_clr(attn_clr),
    .peer_clk_need(peer_clk_need), .cfg_pd_en(cfg_pd_en),
    .settle_cycles(settle_cycles), .host_wake_out(host_wake_out),
    .ref_clk_req(ref_clk_req), .radio_pd(radio_pd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock edge of the expected behaviour, from the requirements
  task automatic model_edge();
    bit wa, ok_sleep, settled;
    int nxt;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_st = 2; m_cnt = 0; m_attn = 0;
      m_clk = 0; m_pd = 4'b1111; m_hw = !cfg_hw_act_hi;
      return;
    end
    wa       = cfg_dw_act_hi ? m_s2 : !m_s2;
    ok_sleep = sleep_ok && !wa;
    settled  = (m_cnt >= int'(settle_cycles));
    nxt = m_st;
    case (m_st)
      0: if (ok_sleep) nxt = 1;
      1: nxt = ok_sleep ? 2 : 0;
      2: if (!ok_sleep) nxt = 3;
      default: if (settled) nxt = 0;
    endcase
    if (m_st != 3) m_cnt = 0;
    else if (!settled) m_cnt = m_cnt + 1;
    m_attn = attn_set || (m_attn && !attn_clr && !wa);
    m_hw   = cfg_hw_act_hi ? m_attn : !m_attn;
    m_clk  = peer_clk_need || (nxt != 2);
    m_pd   = (nxt == 2 || nxt == 3) ? 4'b1111 : cfg_pd_en;
    m_st   = nxt;
    m_s2   = m_s1;
    m_s1   = dev_wake_in;
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(ref_clk_req == m_clk, "R5 ref_clk_req vs model", ref_clk_req, m_clk);
    check(radio_pd == m_pd, "R6 radio_pd vs model", radio_pd, m_pd);
    check(host_wake_out == m_hw, "R8 host_wake_out vs model", host_wake_out, m_hw);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #500us;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    @(negedge clk);
    ticks(2);
    // R9: reset state
    check(ref_clk_req == 1'b0, "R9 clk_req in reset", ref_clk_req, 0);
    check(radio_pd == 4'b1111, "R9 radio_pd in reset", radio_pd, 4'hf);
    check(host_wake_out == 1'b0, "R9 host_wake inactive", host_wake_out, 0);
    rst = 1'b0;
    ticks(5);
    // R3: idle host and criteria met keep the device asleep
    check(ref_clk_req == 1'b0 && radio_pd == 4'b1111, "R3 stays asleep", radio_pd, 4'hf);
    dev_wake_in = 1'b1;
    ticks(2);
    check(ref_clk_req == 1'b0, "R1 sync latency", ref_clk_req, 0);
    tick();
    check(ref_clk_req == 1'b1, "R4 clock request on wake", ref_clk_req, 1);
    ticks(3);
    check(radio_pd == 4'b1111, "R4 held during settle", radio_pd, 4'hf);
    tick();
    check(radio_pd == 4'b0101, "R4 R6 released after settle", radio_pd, 4'h5);
    ticks(6);
    check(ref_clk_req == 1'b1, "R2 wake overrides criteria", ref_clk_req, 1);
    dev_wake_in = 1'b0;
    ticks(3);
    check(ref_clk_req == 1'b1, "R3 pending before sleep", ref_clk_req, 1);
    tick();
    check(ref_clk_req == 1'b0 && radio_pd == 4'b1111, "R3 sleep entered", ref_clk_req, 0);
    // R7 R8: attention handling
    attn_set = 1'b1; tick(); attn_set = 1'b0;
    check(host_wake_out == 1'b1, "R7 request raises host wake", host_wake_out, 1);
    ticks(3);
    check(host_wake_out == 1'b1, "R7 request held", host_wake_out, 1);
    cfg_hw_act_hi = 1'b0; tick();
    check(host_wake_out == 1'b0, "R8 polarity flip", host_wake_out, 0);
    attn_set = 1'b1; attn_clr = 1'b1; tick(); attn_set = 1'b0;
    check(host_wake_out == 1'b0, "R7 set beats clear", host_wake_out, 0);
    tick(); attn_clr = 1'b0;
    check(host_wake_out == 1'b1, "R7 clear drops request", host_wake_out, 1);
    // R1: active-low device-wake
    cfg_dw_act_hi = 1'b0; tick();
    check(ref_clk_req == 1'b1, "R1 active-low wake", ref_clk_req, 1);
    dev_wake_in = 1'b1;
    ticks(12);
    check(ref_clk_req == 1'b0 && radio_pd == 4'b1111, "R3 asleep active-low", ref_clk_req, 0);
    peer_clk_need = 1'b1; tick();
    check(ref_clk_req == 1'b1 && radio_pd == 4'b1111, "R5 peer clock need", ref_clk_req, 1);
    // random phase against the model
    for (int c = 0; c < 6000; c++) begin
      if ($urandom % 8 == 0)   dev_wake_in   = ~dev_wake_in;
      if ($urandom % 6 == 0)   sleep_ok      = ~sleep_ok;
      if ($urandom % 12 == 0)  peer_clk_need = ~peer_clk_need;
      attn_set = ($urandom % 10 == 0);
      attn_clr = ($urandom % 10 == 0);
      if ($urandom % 64 == 0)  cfg_dw_act_hi = ~cfg_dw_act_hi;
      if ($urandom % 64 == 0)  cfg_hw_act_hi = ~cfg_hw_act_hi;
      if ($urandom % 50 == 0)  cfg_pd_en     = 4'($urandom);
      if ($urandom % 40 == 0)  settle_cycles = CNT_W'($urandom % 6);
      rst = ($urandom % 500 == 0);
      tick();
    end
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule